// File: doc/BRIEF.md
# Atomic Wide Clock Snapshot Reader

This block turns three free-running clock registers into one consistent two-word timestamp. The three registers are a high word, a low word and a sub-count that holds finer bits. On a read strobe, the block samples all three on the same clock edge. It drops the least significant bit of the sub-count, adds what is left to the low word, and carries any overflow into the high word.

The result is registered. It appears together with a valid flag one cycle after the strobe. The clock registers sit outside the block and keep advancing while a result is being formed. A tick that lands in the cycle after the strobe therefore cannot mix old and new values in the result. Reads may be issued back to back, one per cycle.

Top module: `clk_snap_reader`

## Requirements
- R1: While reset is asserted, and after reset until the first strobe, `snap_valid` is 0 and both `snap_hi` and `snap_lo` are 0.
- R2: `snap_valid` is 1 in exactly the cycle after each cycle in which `snap_req` was 1 at the clock edge, and 0 otherwise.
- R3: The sub-count is shifted right by one bit, with a 0 entering at bit 15, before it is used. Its bit 0 never affects the result, so a sub-count of 0xFFFF contributes 0x7FFF.
- R4: `snap_lo` equals the sampled low word plus the shifted sub-count, modulo 2^16.
- R5: `snap_hi` equals the sampled high word plus 1 when the R4 addition overflows 16 bits, and the sampled high word otherwise. A high word of 0xFFFF with a carry wraps to 0x0000.
- R6: All three words come from the values present at the same strobe edge. A change of any input in the following cycle does not alter that result.
- R7: A strobe in the cycle in which a result is shown is accepted and produces a fresh result in the next cycle.
- R8: In cycles with `snap_valid` at 0, `snap_hi` and `snap_lo` keep their last values whatever the clock inputs do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| snap_req | input | 1 | Read strobe; take a snapshot at this edge |
| tick_hi | input | 16 | Live high word of the clock |
| tick_lo | input | 16 | Live low word of the clock |
| tick_sub | input | 16 | Live sub-count register holding finer bits |
| snap_valid | output | 1 | Result words are new this cycle |
| snap_hi | output | 16 | Result high word |
| snap_lo | output | 16 | Result low word |

## Verification
Directed snapshots separate the three parts of the arithmetic:
- A sub-count of 0xFFFF against one of 0x0001 shows that the shift drops bit 0 and fills the top with zero.
- Low words just under the 16-bit boundary, with and without enough fraction to overflow, show where the carry starts and that a high word of 0xFFFF wraps.

Several further patterns check timing and consistency:
- A strobe followed at once by changed inputs shows that all words come from one edge.
- Back-to-back strobes show that each request gets its own result with no loss.
- Idle cycles with scrambled inputs show that the outputs hold.
- A long run with a ticking incrementer, read every third cycle, mixes every carry path with live values.

// File: rtl/clk_snap_pkg.sv
package clk_snap_pkg;

  localparam int unsigned SNAP_WORD_W = 16;

  typedef enum logic [0:0] {
    SNAP_IDLE = 1'b0,
    SNAP_SHOW = 1'b1
  } snap_state_e;

endpackage

// File: rtl/snap_frac_align.sv
// Aligns the sub-count to the low word: logical right shift by one, zero fill.
module snap_frac_align #(
  parameter int unsigned SUB_W = 16,
  parameter int unsigned LO_W  = 16
) (
  input  logic [SUB_W-1:0] sub_i,
  output logic [LO_W-1:0]  frac_o
);
  localparam int unsigned SHIFTED_W = SUB_W - 1;

  logic [SUB_W-1:0] shifted;

  always_comb begin
    shifted = sub_i >> 1;
  end

  generate
    if (SHIFTED_W >= LO_W) begin : g_trunc
      assign frac_o = shifted[LO_W-1:0];
    end else begin : g_extend
      assign frac_o = LO_W'(shifted);
    end
  endgenerate
endmodule

// File: rtl/snap_lo_adder.sv
// Adds the aligned fraction to the low word and reports the carry out.
module snap_lo_adder #(
  parameter int unsigned LO_W = 16
) (
  input  logic [LO_W-1:0] lo_i,
  input  logic [LO_W-1:0] frac_i,
  output logic [LO_W-1:0] sum_o,
  output logic            carry_o
);
  localparam int unsigned EXT_W = LO_W + 1;

  logic [EXT_W-1:0] wide_sum;

  always_comb begin
    wide_sum = {1'b0, lo_i} + {1'b0, frac_i};
    sum_o    = wide_sum[LO_W-1:0];
    carry_o  = wide_sum[EXT_W-1];
  end
endmodule

// File: rtl/snap_hi_bump.sv
// Increments the high word by the carry coming out of the low addition.
module snap_hi_bump #(
  parameter int unsigned HI_W = 16
) (
  input  logic [HI_W-1:0] hi_i,
  input  logic            carry_i,
  output logic [HI_W-1:0] hi_o
);
  always_comb begin
    hi_o = hi_i + HI_W'(carry_i);
  end
endmodule

// File: rtl/snap_out_reg.sv
// Result register with written-out enable and a one-bit show state.
module snap_out_reg
  import clk_snap_pkg::*;
#(
  parameter int unsigned HI_W = 16,
  parameter int unsigned LO_W = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            load_i,
  input  logic [HI_W-1:0] hi_i,
  input  logic [LO_W-1:0] lo_i,
  output logic            valid_o,
  output logic [HI_W-1:0] hi_o,
  output logic [LO_W-1:0] lo_o
);
  snap_state_e     state_q, state_d;
  logic [HI_W-1:0] hi_q, hi_d;
  logic [LO_W-1:0] lo_q, lo_d;

  always_comb begin
    state_d = load_i ? SNAP_SHOW : SNAP_IDLE;
    hi_d    = hi_q;
    lo_d    = lo_q;
    if (load_i) begin
      hi_d = hi_i;
      lo_d = lo_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SNAP_IDLE;
      hi_q    <= '0;
      lo_q    <= '0;
    end else begin
      state_q <= state_d;
      hi_q    <= hi_d;
      lo_q    <= lo_d;
    end
  end

  assign valid_o = (state_q == SNAP_SHOW);
  assign hi_o    = hi_q;
  assign lo_o    = lo_q;
endmodule

// File: rtl/clk_snap_reader.sv
// Same-edge snapshot of high, low and sub-count clock words into one timestamp.
module clk_snap_reader
  import clk_snap_pkg::*;
#(
  parameter int unsigned HI_W  = SNAP_WORD_W,
  parameter int unsigned LO_W  = SNAP_WORD_W,
  parameter int unsigned SUB_W = SNAP_WORD_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             snap_req,
  input  logic [HI_W-1:0]  tick_hi,
  input  logic [LO_W-1:0]  tick_lo,
  input  logic [SUB_W-1:0] tick_sub,
  output logic             snap_valid,
  output logic [HI_W-1:0]  snap_hi,
  output logic [LO_W-1:0]  snap_lo
);
  logic [LO_W-1:0] frac;
  logic [LO_W-1:0] lo_sum;
  logic            lo_carry;
  logic [HI_W-1:0] hi_adj;

  snap_frac_align #(.SUB_W(SUB_W), .LO_W(LO_W)) u_align (
    .sub_i  (tick_sub),
    .frac_o (frac)
  );

  snap_lo_adder #(.LO_W(LO_W)) u_lo_add (
    .lo_i    (tick_lo),
    .frac_i  (frac),
    .sum_o   (lo_sum),
    .carry_o (lo_carry)
  );

  snap_hi_bump #(.HI_W(HI_W)) u_hi_bump (
    .hi_i    (tick_hi),
    .carry_i (lo_carry),
    .hi_o    (hi_adj)
  );

  snap_out_reg #(.HI_W(HI_W), .LO_W(LO_W)) u_out (
    .clk     (clk),
    .rst_n   (rst_n),
    .load_i  (snap_req),
    .hi_i    (hi_adj),
    .lo_i    (lo_sum),
    .valid_o (snap_valid),
    .hi_o    (snap_hi),
    .lo_o    (snap_lo)
  );
endmodule

// File: rtl/clk_snap_reader_chk.sv
module clk_snap_reader_chk #(
  parameter int unsigned HI_W  = 16,
  parameter int unsigned LO_W  = 16,
  parameter int unsigned SUB_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             snap_req,
  input logic [HI_W-1:0]  tick_hi,
  input logic [LO_W-1:0]  tick_lo,
  input logic [SUB_W-1:0] tick_sub,
  input logic             snap_valid,
  input logic [HI_W-1:0]  snap_hi,
  input logic [LO_W-1:0]  snap_lo
);
  logic [LO_W:0] ref_sum;
  always_comb begin
    ref_sum = {1'b0, tick_lo} + (LO_W+1)'(tick_sub >> 1);
  end

  // R2
  p_valid_after_req_r2: assert property (@(posedge clk) disable iff (!rst_n)
    snap_req |=> snap_valid);
  // R2
  p_no_stray_valid_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !snap_req |=> !snap_valid);
  // R4, R3, R6
  p_lo_sum_r4: assert property (@(posedge clk) disable iff (!rst_n)
    snap_req |=> (snap_lo == $past(ref_sum[LO_W-1:0])));
  // R5
  p_hi_carry_r5: assert property (@(posedge clk) disable iff (!rst_n)
    snap_req |=> (snap_hi == HI_W'($past(tick_hi) + HI_W'($past(ref_sum[LO_W])))));
  // R8
  p_hold_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !snap_req |=> ($stable(snap_hi) && $stable(snap_lo)));
  // R1
  always_comb begin
    if (!rst_n) begin
      p_reset_clear_r1: assert (!snap_valid && snap_hi == '0 && snap_lo == '0);
    end
  end
endmodule

bind clk_snap_reader clk_snap_reader_chk #(.HI_W(HI_W), .LO_W(LO_W), .SUB_W(SUB_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .snap_req   (snap_req),
  .tick_hi    (tick_hi),
  .tick_lo    (tick_lo),
  .tick_sub   (tick_sub),
  .snap_valid (snap_valid),
  .snap_hi    (snap_hi),
  .snap_lo    (snap_lo)
);

// File: tb/clk_snap_reader_tb.sv
module clk_snap_reader_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        snap_req;
  logic [15:0] tick_hi, tick_lo, tick_sub;
  logic        snap_valid;
  logic [15:0] snap_hi, snap_lo;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;
  logic [31:0] exp_q[$];
  string       tag_q[$];
  logic [15:0] last_hi, last_lo;

  always #5 clk = ~clk;

  clk_snap_reader u_dut (
    .clk(clk), .rst_n(rst_n), .snap_req(snap_req),
    .tick_hi(tick_hi), .tick_lo(tick_lo), .tick_sub(tick_sub),
    .snap_valid(snap_valid), .snap_hi(snap_hi), .snap_lo(snap_lo)
  );

  function automatic logic [31:0] model(input logic [15:0] h, input logic [15:0] l,
                                        input logic [15:0] s);
    logic [16:0] sum;
    sum = {1'b0, l} + {2'b00, s[15:1]};
    return {h + {15'd0, sum[16]}, sum[15:0]};
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] expv);
    total++;
    if (act !== expv) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, expv);
    end
  endtask

  task automatic snap(input string tag, input logic [15:0] h, input logic [15:0] l,
                      input logic [15:0] s);
    @(negedge clk);
    tick_hi  = h;
    tick_lo  = l;
    tick_sub = s;
    snap_req = 1'b1;
    exp_q.push_back(model(h, l, s));
    tag_q.push_back(tag);
  endtask

  task automatic idle_scramble(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      snap_req = 1'b0;
      tick_hi  = tick_hi ^ 16'hA5A5;
      tick_lo  = tick_lo + 16'h3C01;
      tick_sub = ~tick_sub;
    end
  endtask

  // Monitor: compares every cycle after the edge.
  always @(posedge clk) begin : mon
    logic req_now;
    req_now = snap_req;
    #2;
    if (rst_n && !done) begin
      check("R2 valid", {31'd0, snap_valid}, {31'd0, req_now});
      if (req_now) begin
        if (exp_q.size() == 0) begin
          check("R2 unexpected result", 32'd1, 32'd0);
        end else begin
          check(tag_q.pop_front(), {snap_hi, snap_lo}, exp_q.pop_front());
        end
      end else begin
        check("R8 hold", {snap_hi, snap_lo}, {last_hi, last_lo});
      end
      last_hi = snap_hi;
      last_lo = snap_lo;
    end
  end

  initial begin
    #200us;
    total++;
    bad++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [15:0] h, l, s;
    rst_n = 1'b0; snap_req = 1'b0;
    tick_hi = 16'h1111; tick_lo = 16'h2222; tick_sub = 16'h3333;
    last_hi = '0; last_lo = '0;
    repeat (3) @(negedge clk);
    check("R1 reset valid", {31'd0, snap_valid}, 32'd0);
    check("R1 reset words", {snap_hi, snap_lo}, 32'd0);
    rst_n = 1'b1;
    idle_scramble(3);
    check("R1 after reset", {31'd0, snap_valid, snap_hi[0], snap_lo[0]} , 32'd0);

    snap("R4 basic", 16'h0001, 16'h1000, 16'h0040);
    snap("R3 top zero fill", 16'h0000, 16'h0000, 16'hFFFF);
    snap("R3 bit0 dropped", 16'h0000, 16'h0000, 16'h0001);
    idle_scramble(2);
    snap("R5 carry", 16'h1234, 16'hFFF0, 16'h0020);
    snap("R5 wrap high", 16'hFFFF, 16'hFFFF, 16'h0002);
    snap("R5 no carry edge", 16'h0005, 16'hFFFE, 16'h0002);
    idle_scramble(1);
    snap("R6 same edge", 16'h0ABC, 16'h8000, 16'hFFFE);
    idle_scramble(4);
    snap("R7 b2b a", 16'h0001, 16'h0002, 16'h0004);
    snap("R7 b2b b", 16'h0010, 16'hFFFF, 16'h0003);
    snap("R7 b2b c", 16'h0100, 16'h7FFF, 16'hFFFF);
    snap("R7 b2b d", 16'hFFFF, 16'h0000, 16'h0000);
    idle_scramble(5);

    // Live incrementer, read every third cycle (R6).
    h = 16'hFFFE; l = 16'hFF00; s = 16'h0000;
    for (int c = 0; c < 600; c++) begin
      {l, s} = {l, s} + 32'h0000_1357;
      if (l == 16'h0000 && s < 16'h1357) h = h + 16'd1;
      if (c % 3 == 0) begin
        snap("R6 live", h, l, s);
      end else begin
        @(negedge clk);
        snap_req = 1'b0;
        tick_hi = h; tick_lo = l; tick_sub = s;
      end
    end
    idle_scramble(4);
    check("R2 all results seen", exp_q.size(), 32'd0);
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule